// File: doc/BRIEF.md
# Clockwise Thermal Migration Controller

This block is the thermal control unit of a 64-tile many-core array laid out as an 8x8 mesh. Core power is proportional to instruction throughput times frequency, capacitance and the square of the supply voltage. Frequency and voltage are fixed, so the per-core activity value taken from each core's instructions-per-cycle counter is enough to order the cores by heat. At the end of every management interval the block takes a snapshot of all 64 activity values. It ranks the 16 cores of the central 4x4 block and the cores of each of the four outer quadrant regions separately. It then proposes up to four task exchanges, each moving the hottest remaining central task to the coldest core of one outer region. The regions are visited clockwise, so hot work is spread around the edge of the die instead of piling up in one corner.

The interval is a programmable number of time-base ticks. Each exchange is presented as a source/destination pair of core IDs with a valid/ready handshake. Each pair also carries the region code and a five-level heat band for both cores. The task transfer itself happens elsewhere.

The controller is a six-state machine. ST_IDLE waits for the interval timer and, on its start pulse, latches the activity table and goes to ST_SCAN. ST_SCAN walks all core indices once per region, tracking the hottest unused central core and the coldest core of the current region, and goes to ST_DECIDE after the last index. ST_DECIDE goes to ST_OFFER when the central candidate is strictly hotter than the outer one, and to ST_NEXT otherwise. ST_OFFER holds the pair until ready, then goes to ST_NEXT. ST_NEXT returns to ST_SCAN for the next region, or moves to ST_DONE after the fourth region. ST_DONE raises done for one cycle and returns to ST_IDLE.

Top module: `thermal_migrate_ctrl`

## Requirements
- R1: While reset is asserted and right after it, swp_valid, busy and done are low, and the tick counter restarts from zero.
- R2: An interval starts on the tick that brings the count of ticks to period_ticks (a value of 0 acts as 1). busy is high from the following cycle until the cycle after done. A start that falls while busy is dropped, and the tick counter keeps running.
- R3: The activity values (8-bit unsigned, core i at act_in[8*i +: 8]) are sampled on the clock edge that starts the interval. Later changes to act_in do not affect that interval.
- R4: A core ID is row*8+col, with row 0 at the top. Central cores are rows 2..5 with cols 2..5. Outer region codes, excluding central cores, are: 0 = rows 0..3/cols 4..7, 1 = rows 4..7/cols 4..7, 2 = rows 4..7/cols 0..3, 3 = rows 0..3/cols 0..3. Every source is central, and every destination lies in the region reported on swp_region.
- R5: Each interval considers the regions in the order 0, 1, 2, 3, with at most one pair per region, so at most four pairs.
- R6: The source is the central core with the highest snapshot activity that has not already been the source of an accepted pair in this interval. Ties go to the lower core ID.
- R7: The destination is the core of the current region with the lowest snapshot activity. Ties go to the lower core ID.
- R8: A pair is issued only when the source activity is strictly greater than the destination activity. Otherwise the region is skipped, and the central core stays available for later regions.
- R9: The heat bands are 0 for activity below 5, 1 below 10, 2 below 15, 3 below 20, and 4 from 20 up. They are reported for the source and the destination.
- R10: While swp_valid is high and swp_ready is low, every swp_* field is held stable. A pair is consumed on the edge where both are high.
- R11: done is a single-cycle pulse, raised only after every pair of the interval has been consumed or skipped, with swp_valid low. busy falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base pulse counted toward the interval |
| period_ticks | input | 16 | Interval length in ticks |
| act_in | input | 512 | 64 packed 8-bit activity values |
| swp_valid | output | 1 | An exchange pair is offered |
| swp_ready | input | 1 | Consumer accepts the offered pair |
| swp_src | output | 6 | Central core whose task moves out |
| swp_dst | output | 6 | Outer core that receives it |
| swp_region | output | 2 | Region code of the destination |
| swp_src_band | output | 3 | Heat band of the source |
| swp_dst_band | output | 3 | Heat band of the destination |
| busy | output | 1 | Interval processing in progress |
| done | output | 1 | One-cycle end-of-interval pulse |

## Verification
The bench covers equal-activity ties and checks that the lowest core ID wins in both rankings; a design that broke ties the other way would swap in the wrong cores. It also uses a pattern where the hottest central task cannot beat the first region but can beat the second. A design that consumed the central core on a skipped region, or that compared with greater-or-equal, would issue a different pair or an extra one. The bench drives activities sitting exactly on the band thresholds, rewrites act_in in the middle of an interval, and uses a short period (and a zero period) so that starts land while busy. A design that re-read live inputs, misplaced a band edge or restarted mid-interval would show wrong fields or a busy flag out of step with the tick count.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
    localparam int REGION_CNT = 4;
    localparam int REGION_W   = 2;
    localparam int BAND_W     = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DECIDE,
        ST_OFFER,
        ST_NEXT,
        ST_DONE
    } mig_state_e;
endpackage

// File: rtl/tmc_interval_timer.sv
module tmc_interval_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PER_W-1:0] period_ticks,
    output logic             start
);
    logic [PER_W-1:0] cnt;
    logic [PER_W:0]   cnt_inc;
    logic             wrap;

    assign cnt_inc = {1'b0, cnt} + {{PER_W{1'b0}}, 1'b1};
    assign wrap    = cnt_inc >= {1'b0, period_ticks};
    assign start   = tick && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= wrap ? '0 : cnt_inc[PER_W-1:0];
        end
    end
endmodule

// File: rtl/tmc_act_table.sv
module tmc_act_table #(
    parameter int N_CORES = 64,
    parameter int ACT_W   = 8,
    parameter int IDX_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [N_CORES*ACT_W-1:0] act_in,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [ACT_W-1:0]         rd_act
);
    logic [ACT_W-1:0] slot [N_CORES];

    for (genvar i = 0; i < N_CORES; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else if (load) begin
                slot[i] <= act_in[i*ACT_W +: ACT_W];
            end
        end
    end

    assign rd_act = slot[rd_idx];
endmodule

// File: rtl/tmc_floorplan.sv
module tmc_floorplan
    import tmc_pkg::*;
#(
    parameter int MESH_DIM = 8,
    parameter int N_CORES  = MESH_DIM * MESH_DIM
) (
    output logic [N_CORES-1:0]          central_mask,
    output logic [N_CORES*REGION_W-1:0] quad_code
);
    localparam int LO   = MESH_DIM / 4;
    localparam int HI   = MESH_DIM - MESH_DIM / 4;
    localparam int HALF = MESH_DIM / 2;

    for (genvar i = 0; i < N_CORES; i++) begin : g_core
        localparam int ROW = i / MESH_DIM;
        localparam int COL = i % MESH_DIM;
        localparam bit CEN = (ROW >= LO) && (ROW < HI) && (COL >= LO) && (COL < HI);
        localparam bit TOP = ROW < HALF;
        localparam bit RGT = COL >= HALF;
        localparam logic [REGION_W-1:0] QC = TOP ? (RGT ? 2'd0 : 2'd3)
                                                 : (RGT ? 2'd1 : 2'd2);
        assign central_mask[i]                   = CEN;
        assign quad_code[i*REGION_W +: REGION_W] = QC;
    end
endmodule

// File: rtl/tmc_band_classify.sv
module tmc_band_classify
    import tmc_pkg::*;
#(
    parameter int ACT_W = 8,
    parameter int TH1   = 5,
    parameter int TH2   = 10,
    parameter int TH3   = 15,
    parameter int TH4   = 20
) (
    input  logic [ACT_W-1:0]  act,
    output logic [BAND_W-1:0] band
);
    always_comb begin
        if (act < ACT_W'(TH1))      band = 3'd0;
        else if (act < ACT_W'(TH2)) band = 3'd1;
        else if (act < ACT_W'(TH3)) band = 3'd2;
        else if (act < ACT_W'(TH4)) band = 3'd3;
        else                        band = 3'd4;
    end
endmodule

// File: rtl/thermal_migrate_ctrl.sv
module thermal_migrate_ctrl
    import tmc_pkg::*;
#(
    parameter int MESH_DIM = 8,
    parameter int ACT_W    = 8,
    parameter int PER_W    = 16,
    parameter int TH1      = 5,
    parameter int TH2      = 10,
    parameter int TH3      = 15,
    parameter int TH4      = 20,
    localparam int N_CORES = MESH_DIM * MESH_DIM,
    localparam int IDX_W   = $clog2(N_CORES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [PER_W-1:0]         period_ticks,
    input  logic [N_CORES*ACT_W-1:0] act_in,
    output logic                     swp_valid,
    input  logic                     swp_ready,
    output logic [IDX_W-1:0]         swp_src,
    output logic [IDX_W-1:0]         swp_dst,
    output logic [REGION_W-1:0]      swp_region,
    output logic [BAND_W-1:0]        swp_src_band,
    output logic [BAND_W-1:0]        swp_dst_band,
    output logic                     busy,
    output logic                     done
);
    mig_state_e state, state_nxt;

    logic                          start;
    logic                          tbl_load;
    logic [ACT_W-1:0]              rd_act;
    logic [IDX_W-1:0]              scan_idx;
    logic [REGION_W-1:0]           region;
    logic [N_CORES-1:0]            used;
    logic [N_CORES-1:0]            central_mask;
    logic [N_CORES*REGION_W-1:0]   quad_code;
    logic                          have_c, have_p;
    logic [IDX_W-1:0]              c_idx, p_idx;
    logic [ACT_W-1:0]              c_act, p_act;
    logic                          scan_last, region_last;
    logic                          is_c, is_p, take_c, take_p, gain;
    logic [BAND_W-1:0]             c_band, p_band;

    // interval time base (R2)
    tmc_interval_timer #(.PER_W(PER_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .period_ticks (period_ticks),
        .start        (start)
    );

    // snapshot of activities taken when an interval is accepted (R3)
    assign tbl_load = (state == ST_IDLE) && start;

    tmc_act_table #(.N_CORES(N_CORES), .ACT_W(ACT_W), .IDX_W(IDX_W)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tbl_load),
        .act_in (act_in),
        .rd_idx (scan_idx),
        .rd_act (rd_act)
    );

    // constant floor-plan decode (R4)
    tmc_floorplan #(.MESH_DIM(MESH_DIM), .N_CORES(N_CORES)) u_plan (
        .central_mask (central_mask),
        .quad_code    (quad_code)
    );

    // heat bands of the two candidates (R9)
    tmc_band_classify #(.ACT_W(ACT_W), .TH1(TH1), .TH2(TH2), .TH3(TH3), .TH4(TH4)) u_band_src (
        .act  (c_act),
        .band (c_band)
    );
    tmc_band_classify #(.ACT_W(ACT_W), .TH1(TH1), .TH2(TH2), .TH3(TH3), .TH4(TH4)) u_band_dst (
        .act  (p_act),
        .band (p_band)
    );

    // scan qualifiers: strict compares in ascending index order keep the lower ID on ties (R6, R7)
    assign scan_last   = scan_idx == IDX_W'(N_CORES - 1);
    assign region_last = region == REGION_W'(REGION_CNT - 1);
    assign is_c   = central_mask[scan_idx] && !used[scan_idx];
    assign is_p   = !central_mask[scan_idx] &&
                    (quad_code[scan_idx*REGION_W +: REGION_W] == region);
    assign take_c = is_c && (!have_c || (rd_act > c_act));
    assign take_p = is_p && (!have_p || (rd_act < p_act));
    // strict gain rule (R8)
    assign gain   = have_c && have_p && (c_act > p_act);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (start)       state_nxt = ST_SCAN;
            ST_SCAN:   if (scan_last)   state_nxt = ST_DECIDE;
            ST_DECIDE: state_nxt = gain ? ST_OFFER : ST_NEXT;
            ST_OFFER:  if (swp_ready)   state_nxt = ST_NEXT;
            ST_NEXT:   state_nxt = region_last ? ST_DONE : ST_SCAN;
            ST_DONE:   state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // ranking datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_idx <= '0;
            region   <= '0;
            used     <= '0;
            have_c   <= 1'b0;
            have_p   <= 1'b0;
            c_idx    <= '0;
            p_idx    <= '0;
            c_act    <= '0;
            p_act    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        region   <= '0;
                        used     <= '0;
                        scan_idx <= '0;
                        have_c   <= 1'b0;
                        have_p   <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (take_c) begin
                        have_c <= 1'b1;
                        c_idx  <= scan_idx;
                        c_act  <= rd_act;
                    end
                    if (take_p) begin
                        have_p <= 1'b1;
                        p_idx  <= scan_idx;
                        p_act  <= rd_act;
                    end
                    if (!scan_last) scan_idx <= scan_idx + 1'b1;
                end
                ST_OFFER: begin
                    // a central core leaves the pool only when its pair is consumed (R6, R10)
                    if (swp_ready) used[c_idx] <= 1'b1;
                end
                ST_NEXT: begin
                    // clockwise step to the next region (R5)
                    region   <= region + 1'b1;
                    scan_idx <= '0;
                    have_c   <= 1'b0;
                    have_p   <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        swp_valid    = (state == ST_OFFER);
        swp_src      = c_idx;
        swp_dst      = p_idx;
        swp_region   = region;
        swp_src_band = c_band;
        swp_dst_band = p_band;
        busy         = (state != ST_IDLE);
        done         = (state == ST_DONE);
    end
endmodule

// File: rtl/thermal_migrate_ctrl_chk.sv
module thermal_migrate_ctrl_chk #(
    parameter int MESH_DIM = 8,
    parameter int IDX_W    = 6,
    parameter int REGION_W = 2,
    parameter int BAND_W   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                swp_valid,
    input logic                swp_ready,
    input logic [IDX_W-1:0]    swp_src,
    input logic [IDX_W-1:0]    swp_dst,
    input logic [REGION_W-1:0] swp_region,
    input logic [BAND_W-1:0]   swp_src_band,
    input logic [BAND_W-1:0]   swp_dst_band,
    input logic                busy,
    input logic                done
);
    int  s_row, s_col, d_row, d_col, d_quad;
    logic src_cen, dst_cen;

    always_comb begin
        s_row   = int'(swp_src) / MESH_DIM;
        s_col   = int'(swp_src) % MESH_DIM;
        d_row   = int'(swp_dst) / MESH_DIM;
        d_col   = int'(swp_dst) % MESH_DIM;
        src_cen = (s_row >= MESH_DIM/4) && (s_row < MESH_DIM - MESH_DIM/4) &&
                  (s_col >= MESH_DIM/4) && (s_col < MESH_DIM - MESH_DIM/4);
        dst_cen = (d_row >= MESH_DIM/4) && (d_row < MESH_DIM - MESH_DIM/4) &&
                  (d_col >= MESH_DIM/4) && (d_col < MESH_DIM - MESH_DIM/4);
        if (d_row < MESH_DIM/2) d_quad = (d_col >= MESH_DIM/2) ? 0 : 3;
        else                    d_quad = (d_col >= MESH_DIM/2) ? 1 : 2;
    end

    // R4
    src_central_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swp_valid |-> src_cen);

    // R4
    dst_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swp_valid |-> (!dst_cen && (d_quad == int'(swp_region))));

    // R8
    band_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swp_valid |-> (swp_src_band >= swp_dst_band));

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swp_valid && !swp_ready) |=> (swp_valid && $stable(swp_src) && $stable(swp_dst)
                                       && $stable(swp_region) && $stable(swp_src_band)
                                       && $stable(swp_dst_band)));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !swp_valid);

    // R2
    offer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swp_valid || done) |-> busy);
endmodule

bind thermal_migrate_ctrl thermal_migrate_ctrl_chk #(
    .MESH_DIM (MESH_DIM),
    .IDX_W    (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .swp_valid    (swp_valid),
    .swp_ready    (swp_ready),
    .swp_src      (swp_src),
    .swp_dst      (swp_dst),
    .swp_region   (swp_region),
    .swp_src_band (swp_src_band),
    .swp_dst_band (swp_dst_band),
    .busy         (busy),
    .done         (done)
);

// File: tb/thermal_migrate_ctrl_test.sv
`timescale 1ns/1ps
module thermal_migrate_ctrl_test;
    localparam int N     = 64;
    localparam int PER_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             swp_ready = 1'b0;
    logic [PER_W-1:0] period_ticks = 16'd120;
    logic [N*8-1:0]   act_in = '0;
    logic             swp_valid, busy, done;
    logic [5:0]       swp_src, swp_dst;
    logic [1:0]       swp_region;
    logic [2:0]       swp_src_band, swp_dst_band;

    always #10 clk = ~clk;

    thermal_migrate_ctrl uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .period_ticks(period_ticks),
        .act_in(act_in), .swp_valid(swp_valid), .swp_ready(swp_ready),
        .swp_src(swp_src), .swp_dst(swp_dst), .swp_region(swp_region),
        .swp_src_band(swp_src_band), .swp_dst_band(swp_dst_band),
        .busy(busy), .done(done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint actv, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, actv, expv);
        end
    endtask

    function automatic bit is_cen(int i);
        int r = i / 8;
        int c = i % 8;
        return (r >= 2) && (r <= 5) && (c >= 2) && (c <= 5);
    endfunction

    function automatic int reg_of(int i);
        int r = i / 8;
        int c = i % 8;
        if (r < 4) return (c >= 4) ? 0 : 3;
        return (c >= 4) ? 1 : 2;
    endfunction

    function automatic int band_of(int a);
        if (a < 5)  return 0;
        if (a < 10) return 1;
        if (a < 15) return 2;
        if (a < 20) return 3;
        return 4;
    endfunction

    function automatic logic [7:0] pat_val(int p, int i);
        case (p)
            0: return 8'((i * 37 + 11) % 32);
            1: return 8'd10;
            2: return is_cen(i) ? 8'd30 : 8'd3;
            3: begin
                if (is_cen(i)) return (i == 18) ? 8'd12 : 8'd0;
                case (reg_of(i))
                    0: return 8'd15;
                    1: return 8'd5;
                    2: return 8'd20;
                    default: return 8'd1;
                endcase
            end
            4: begin
                if (i == 18) return 8'd20;
                if (i == 27) return 8'd15;
                if (i == 36) return 8'd10;
                if (i == 45) return 8'd5;
                if (is_cen(i)) return 8'd0;
                case (reg_of(i))
                    0, 3: return 8'd4;
                    default: return 8'd9;
                endcase
            end
            5: return 8'((i * 101 + 7) % 256);
            default: return is_cen(i) ? 8'd0 : 8'd200;
        endcase
    endfunction

    // reference model state
    int          m_cnt = 0;
    bit          m_busy = 0;
    int          n_done = 0;
    logic [19:0] exp_q[$];
    int          snap[N];
    bit          prev_valid = 0;
    bit          prev_done = 0;
    logic [19:0] prev_out = '0;
    int          cyc = 0;

    logic             smp_tick = 0, smp_ready = 0, smp_rst_n = 0;
    logic [N*8-1:0]   smp_act = '0;
    logic [PER_W-1:0] smp_period = '0;

    always @(posedge clk) begin
        smp_tick   <= tick;
        smp_ready  <= swp_ready;
        smp_act    <= act_in;
        smp_rst_n  <= rst_n;
        smp_period <= period_ticks;
    end

    task automatic build_expect(input logic [N*8-1:0] a);
        bit used[N];
        for (int i = 0; i < N; i++) begin
            snap[i] = int'(a[i*8 +: 8]);
            used[i] = 0;
        end
        exp_q.delete();
        for (int r = 0; r < 4; r++) begin
            int bc = -1;
            int bp = -1;
            for (int i = 0; i < N; i++) begin
                if (is_cen(i) && !used[i] && (bc < 0 || snap[i] > snap[bc])) bc = i;
                if (!is_cen(i) && reg_of(i) == r && (bp < 0 || snap[i] < snap[bp])) bp = i;
            end
            if (snap[bc] > snap[bp]) begin
                exp_q.push_back({2'(r), 6'(bc), 6'(bp), 3'(band_of(snap[bc])), 3'(band_of(snap[bp]))});
                used[bc] = 1;
            end
        end
    endtask

    always @(negedge clk) begin
        logic [19:0] out_w;
        bit          started;
        bit          accept;
        out_w = {swp_region, swp_src, swp_dst, swp_src_band, swp_dst_band};
        cyc++;
        if (!smp_rst_n) begin
            m_cnt = 0;
            m_busy = 0;
            exp_q.delete();
            chk(!swp_valid && !busy && !done, "R1", "outputs in reset",
                {swp_valid, busy, done}, 0);
        end else begin
            if (prev_valid && smp_ready && exp_q.size() > 0) void'(exp_q.pop_front());
            started = 0;
            if (smp_tick) begin
                if (m_cnt + 1 >= int'(smp_period)) begin
                    m_cnt = 0;
                    started = 1;
                end else begin
                    m_cnt++;
                end
            end
            accept = started && !m_busy;
            if (prev_done) begin
                m_busy = 0;
                chk(exp_q.size() == 0, "R11", "pairs left at interval end", exp_q.size(), 0);
            end
            if (accept) begin
                build_expect(smp_act);
                m_busy = 1;
            end
            chk(busy == m_busy, "R2", "busy", busy, m_busy);
            if (done) begin
                n_done++;
                chk(exp_q.size() == 0, "R11", "done with pending pairs", exp_q.size(), 0);
            end
            if (swp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R5", "unexpected pair", out_w, 0);
                end else begin
                    logic [19:0] e;
                    e = exp_q[0];
                    chk(swp_region == e[19:18], "R5", "region order", swp_region, e[19:18]);
                    chk(swp_src == e[17:12], "R3 R6", "source core", swp_src, e[17:12]);
                    chk(swp_dst == e[11:6], "R7", "destination core", swp_dst, e[11:6]);
                    chk(swp_src_band == e[5:3], "R9", "source band", swp_src_band, e[5:3]);
                    chk(swp_dst_band == e[2:0], "R9", "destination band", swp_dst_band, e[2:0]);
                end
                chk(snap[swp_src] > snap[swp_dst], "R8", "gain not strict",
                    snap[swp_src], snap[swp_dst] + 1);
                chk(is_cen(swp_src) && !is_cen(swp_dst) && reg_of(swp_dst) == int'(swp_region),
                    "R4", "floor-plan placement", swp_dst, swp_region);
                if (prev_valid && !smp_ready)
                    chk(out_w == prev_out, "R10", "fields moved while stalled", out_w, prev_out);
            end else if (prev_valid && !smp_ready) begin
                chk(0, "R10", "offer withdrawn while stalled", 0, 1);
            end
        end
        prev_valid = swp_valid;
        prev_done  = done;
        prev_out   = out_w;
        tick      = (cyc % 3) != 1;
        swp_ready = ((cyc % 5) != 2) && ((cyc % 7) != 4);
    end

    task automatic wait_busy(input bit level);
        do begin
            @(negedge clk);
            #1;
        end while (m_busy != level);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < 7; p++) begin
            if (p == 5) period_ticks = 16'd40;
            if (p == 6) period_ticks = 16'd0;
            if (m_busy) wait_busy(1'b0);
            for (int i = 0; i < N; i++) act_in[i*8 +: 8] = pat_val(p, i);
            wait_busy(1'b1);
            act_in = ~act_in;   // R3: live changes must not reach this interval
            wait_busy(1'b0);
        end
        repeat (3) @(negedge clk);
        chk(n_done == 7, "R11", "done pulses", n_done, 7);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule